// File: doc/BRIEF.md
# Flash Update Programming Sequencer

This block writes a replacement configuration image into the upper part of a serial NOR flash on behalf of a host processor. The lower part of the flash keeps a protected fallback image and is never modified. The host asks for one of three operations: erase a 64 KiB sector, program a run of bytes, or read a run of bytes back. Each request carries a 24-bit flash address and a byte count. Program data arrives on a valid/ready byte stream, and read data leaves on a valid-only byte stream.

On the flash side, the block drives a byte-level command port toward a simple SPI shift engine. That port has a FIFO flush strobe, a transmit byte load, a chip select and a clock-run enable. Received bytes come back on a receive head byte with a pop strobe. Every flash access runs the same fixed sequence. The FIFOs are flushed first. Then the command, address and payload bytes are loaded with chip select released. Then chip select is asserted, and after that clocking is enabled. Once the shifter drains, chip select is released and clocking is stopped. Any received bytes are collected after that.

The block inserts a write-enable access before every erase and every program. It splits long programs so that no burst crosses a 256-byte page or overflows the FIFO. After each modifying access it polls the flash status until the busy bit clears.

Top module: `flash_update_seq`

## Requirements
- R1: After reset, chip select is high (`spi_cs_n`=1), `spi_run`=0, `busy`=0 and `req_ready`=1.
- R2: `req_op` encodes 0=erase, 1=program, 2=read and 3=invalid. An erase or program whose address is below `UPDATE_BASE` (default 0xF50000), or any request with code 3, is consumed with a one-cycle `err` pulse and no `done`. No flash access takes place and chip select stays high. Reads below the base are allowed.
- R3: Every erase (0xD8) and program (0x02) access is preceded by its own one-byte access carrying 0x06, with its own chip-select assertion and release.
- R4: Command codes are 0x06 write enable, 0xD8 sector erase, 0x02 page program, 0x03 read and 0x05 read status. An erase is four bytes: the opcode, then the 24-bit address with the most significant byte first. Program and read place the same three address bytes after the opcode.
- R5: For each access, the flush strobe comes first, with chip select high and clocking off. Bytes are loaded only while chip select is high and clocking is off. Chip select falls while clocking is off, and clocking starts while chip select is low. Chip select rises while clocking is still on, and clocking then stops with chip select high.
- R6: A program access carries at most `FIFO_DEPTH` bytes including its 4 header bytes, and never crosses a 256-byte page. Longer requests are split into consecutive bursts. With depth 16, 30 bytes at 0xF500FA become bursts of 6, 12 and 12 bytes. Each payload byte is taken from the write stream exactly once and in order.
- R7: After each erase or program access, status reads (0x05 followed by one dummy byte) repeat while bit 0 of the returned status is 1. No other command is issued until that bit reads 0.
- R8: A read access sends 0x03, the address, and one 0x00 dummy byte per wanted data byte. After chip select is released, the four header reply bytes are discarded and each data byte is presented on `rd_data` with `rd_valid`, in address order. Reads are split under the same FIFO and page limits as programs.
- R9: An erase request sends a single 0xD8 access for the requested address. Afterwards, read-back of that sector returns 0xFF.
- R10: `done` pulses exactly once per accepted request. `busy` is high and `req_ready` is low from acceptance to completion. A program or read request with a zero count completes with `done` and no flash access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 erase, 1 program, 2 read, 3 invalid |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Byte count for program or read |
| wr_valid | input | 1 | Program byte available |
| wr_ready | output | 1 | Program byte taken this cycle |
| wr_data | input | 8 | Program byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| spi_flush | output | 1 | Clear both shifter FIFOs |
| spi_tx_valid | output | 1 | Load `spi_tx_byte` into the transmit FIFO |
| spi_tx_byte | output | 8 | Transmit byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_run | output | 1 | Enable shifter clocking |
| spi_idle | input | 1 | Transmit FIFO empty and shifter quiet |
| spi_rx_pop | output | 1 | Pop the receive FIFO head |
| spi_rx_byte | input | 8 | Receive FIFO head byte |

## Verification
The assertions rely on the shift engine behaving as described here. It shifts only while chip select is low and clocking is on. `spi_idle` stays low while loaded bytes remain. There is one received byte for each byte sent. The receive head is valid whenever popped. The bench models that engine and a flash device behind it with a status busy bit that stays set for two polls. The host side keeps requests within the protocol: a request is presented only while `req_ready` is high, and a program request's bytes are offered on the write stream with periodic stalls. Addresses, counts and page offsets are chosen to hit the base boundary, page crossings and FIFO-limited splitting.

// File: rtl/fus_pkg.sv
package fus_pkg;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_ERASE = 8'hD8;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_STAT  = 8'h05;
  localparam logic [7:0] FILLER    = 8'h00;
  localparam int         HDR_BYTES = 4;

  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_PROG  = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WREN = 2'd1,
    PH_MAIN = 2'd2,
    PH_POLL = 2'd3
  } phase_e;

  // payload bytes in the next burst: limited by remaining count, FIFO room, page room
  function automatic int unsigned burst_len(input logic [23:0] addr,
                                            input int unsigned remain,
                                            input int unsigned depth,
                                            input int unsigned page);
    int unsigned a, room_page, room_fifo, n;
    a         = {8'd0, addr};
    room_page = page - (a % page);
    room_fifo = depth - HDR_BYTES;
    n         = remain;
    if (room_fifo < n) n = room_fifo;
    if (room_page < n) n = room_page;
    return n;
  endfunction

  function automatic logic is_rejected(input op_e op, input logic [23:0] addr,
                                       input logic [23:0] base);
    return (op == OP_NONE) || ((op != OP_READ) && (addr < base));
  endfunction

  function automatic logic [7:0] opcode_of(input op_e op);
    case (op)
      OP_ERASE: return CMD_ERASE;
      OP_PROG:  return CMD_PROG;
      default:  return CMD_READ;
    endcase
  endfunction

  // header position 1..3 carries the address, most significant byte first
  function automatic logic [7:0] addr_byte(input logic [23:0] addr, input int unsigned pos);
    case (pos)
      1:       return addr[23:16];
      2:       return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/fus_bytegen.sv
module fus_bytegen
  import fus_pkg::*;
#(
  parameter int CW = 5
) (
  input  phase_e          phase,
  input  op_e             op,
  input  logic            loading,
  input  logic [CW-1:0]   idx,
  input  logic [23:0]     addr,
  input  logic            wr_valid,
  input  logic [7:0]      wr_data,
  output logic [7:0]      tx_byte,
  output logic            byte_ok,
  output logic            wr_take
);

  logic in_header;
  assign in_header = (idx < CW'(HDR_BYTES));

  always_comb begin
    tx_byte = FILLER;
    byte_ok = loading;
    wr_take = 1'b0;
    case (phase)
      PH_WREN: tx_byte = CMD_WREN;
      PH_POLL: tx_byte = (idx == '0) ? CMD_STAT : FILLER;
      PH_MAIN: begin
        if (idx == '0) begin
          tx_byte = opcode_of(op);
        end else if (in_header) begin
          tx_byte = addr_byte(addr, 32'(idx));
        end else if (op == OP_PROG) begin
          tx_byte = wr_data;
          byte_ok = loading && wr_valid;
          wr_take = loading && wr_valid;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fus_txn.sv
module fus_txn #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] n_tx,
  input  logic [CW-1:0] n_rx,
  input  logic          byte_ok,
  input  logic [7:0]    byte_in,
  input  logic          spi_idle,
  output logic          loading,
  output logic [CW-1:0] tx_idx,
  output logic [CW-1:0] rx_idx,
  output logic          rx_fire,
  output logic          done,
  output logic          spi_flush,
  output logic          spi_tx_valid,
  output logic [7:0]    spi_tx_byte,
  output logic          spi_cs_n,
  output logic          spi_run,
  output logic          spi_rx_pop
);

  typedef enum logic [2:0] {
    E_IDLE, E_FLUSH, E_LOAD, E_SEL, E_RUN, E_DESEL, E_HALT, E_DRAIN
  } est_e;

  est_e es;

  logic tx_last, rx_last, drain_skip;
  assign loading    = (es == E_LOAD);
  assign tx_last    = loading && byte_ok && (tx_idx == n_tx - 1'b1);
  assign rx_fire    = (es == E_DRAIN);
  assign rx_last    = rx_fire && (rx_idx == n_rx - 1'b1);
  assign drain_skip = (es == E_HALT) && (n_rx == '0);
  assign done       = drain_skip || rx_last;

  assign spi_flush    = (es == E_FLUSH);
  assign spi_tx_valid = loading && byte_ok;
  assign spi_tx_byte  = byte_in;
  assign spi_cs_n     = !((es == E_SEL) || (es == E_RUN));
  assign spi_run      = (es == E_RUN) || (es == E_DESEL);
  assign spi_rx_pop   = rx_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      es     <= E_IDLE;
      tx_idx <= '0;
      rx_idx <= '0;
    end else begin
      case (es)
        E_IDLE:  if (start) es <= E_FLUSH;
        E_FLUSH: begin
          tx_idx <= '0;
          es     <= E_LOAD;
        end
        E_LOAD: if (byte_ok) begin
          if (tx_last) es <= E_SEL;
          else         tx_idx <= tx_idx + 1'b1;
        end
        E_SEL:   es <= E_RUN;
        E_RUN:   if (spi_idle) es <= E_DESEL;
        E_DESEL: es <= E_HALT;
        E_HALT: begin
          rx_idx <= '0;
          es     <= (n_rx == '0) ? E_IDLE : E_DRAIN;
        end
        E_DRAIN: begin
          if (rx_last) es <= E_IDLE;
          else         rx_idx <= rx_idx + 1'b1;
        end
        default: es <= E_IDLE;
      endcase
    end
  end

  AST_LOAD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> (spi_cs_n && !spi_run)); // R5
  AST_SELECT_THEN_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_run) |-> (!spi_cs_n && $past(!spi_cs_n))); // R5
  AST_RELEASE_WHILE_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> spi_run); // R5
  AST_STOP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_run) |-> spi_cs_n); // R5
  AST_DRAIN_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_rx_pop |-> (spi_cs_n && !spi_run)); // R8

endmodule

// File: rtl/flash_update_seq.sv
module flash_update_seq
  import fus_pkg::*;
#(
  parameter int          FIFO_DEPTH  = 16,
  parameter int          PAGE_BYTES  = 256,
  parameter int          LEN_W       = 12,
  parameter logic [23:0] UPDATE_BASE = 24'hF50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             spi_flush,
  output logic             spi_tx_valid,
  output logic [7:0]       spi_tx_byte,
  output logic             spi_cs_n,
  output logic             spi_run,
  input  logic             spi_idle,
  output logic             spi_rx_pop,
  input  logic [7:0]       spi_rx_byte
);

  localparam int CW         = $clog2(FIFO_DEPTH + 1);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

  phase_e           st;
  op_e              op;
  logic [23:0]      cur_addr;
  logic [LEN_W-1:0] remain;
  logic [CW-1:0]    chunk;
  logic             kick;
  logic             wren_ok;

  logic [CW-1:0] n_tx, n_rx, tx_idx, rx_idx;
  logic          loading, byte_ok, rx_fire, eng_done;
  logic [7:0]    tx_byte;

  // named internal events
  logic             req_take, req_bad, req_empty;
  op_e              req_kind;
  logic             main_start, main_end, wren_end, poll_end, poll_wip;
  logic [23:0]      nx_addr;
  logic [LEN_W-1:0] nx_remain;
  logic [23:0]      burst_last;

  assign req_kind   = op_e'(req_op);
  assign req_take   = (st == PH_IDLE) && req_valid;
  assign req_bad    = is_rejected(req_kind, req_addr, UPDATE_BASE);
  assign req_empty  = (req_kind != OP_ERASE) && (req_len == '0);
  assign main_start = (st == PH_MAIN) && kick;
  assign main_end   = (st == PH_MAIN) && eng_done;
  assign wren_end   = (st == PH_WREN) && eng_done;
  assign poll_end   = (st == PH_POLL) && eng_done;
  assign poll_wip   = spi_rx_byte[0];
  assign nx_addr    = cur_addr + 24'(chunk);
  assign nx_remain  = remain - LEN_W'(chunk);
  assign burst_last = cur_addr + 24'(chunk) - 24'd1;

  always_comb begin
    n_tx = CW'(1);
    n_rx = '0;
    case (st)
      PH_POLL: begin
        n_tx = CW'(2);
        n_rx = CW'(2);
      end
      PH_MAIN: begin
        n_tx = (op == OP_ERASE) ? CW'(HDR_BYTES) : CW'(HDR_BYTES) + chunk;
        n_rx = (op == OP_READ) ? CW'(HDR_BYTES) + chunk : '0;
      end
      default: ;
    endcase
  end

  assign req_ready = (st == PH_IDLE);
  assign busy      = (st != PH_IDLE);
  assign rd_valid  = (st == PH_MAIN) && (op == OP_READ) && rx_fire &&
                     (rx_idx >= CW'(HDR_BYTES));
  assign rd_data   = spi_rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      op       <= OP_NONE;
      cur_addr <= '0;
      remain   <= '0;
      chunk    <= '0;
      kick     <= 1'b0;
      wren_ok  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      kick <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      if (wren_end) wren_ok <= 1'b1;
      if (main_end) wren_ok <= 1'b0;
      case (st)
        PH_IDLE: if (req_take) begin
          if (req_bad) begin
            err <= 1'b1;
          end else if (req_empty) begin
            done <= 1'b1;
          end else begin
            op       <= req_kind;
            cur_addr <= req_addr;
            remain   <= req_len;
            chunk    <= (req_kind == OP_ERASE) ? '0 :
                        CW'(burst_len(req_addr, 32'(req_len), FIFO_DEPTH, PAGE_BYTES));
            st       <= (req_kind == OP_READ) ? PH_MAIN : PH_WREN;
            kick     <= 1'b1;
          end
        end
        PH_WREN: if (eng_done) begin
          st   <= PH_MAIN;
          kick <= 1'b1;
        end
        PH_MAIN: if (eng_done) begin
          if (op == OP_READ) begin
            if (nx_remain == '0) begin
              st   <= PH_IDLE;
              done <= 1'b1;
            end else begin
              cur_addr <= nx_addr;
              remain   <= nx_remain;
              chunk    <= CW'(burst_len(nx_addr, 32'(nx_remain), FIFO_DEPTH, PAGE_BYTES));
              kick     <= 1'b1;
            end
          end else begin
            if (op == OP_PROG) begin
              cur_addr <= nx_addr;
              remain   <= nx_remain;
            end
            st   <= PH_POLL;
            kick <= 1'b1;
          end
        end
        PH_POLL: if (eng_done) begin
          if (poll_wip) begin
            kick <= 1'b1;
          end else if ((op == OP_PROG) && (remain != '0)) begin
            chunk <= CW'(burst_len(cur_addr, 32'(remain), FIFO_DEPTH, PAGE_BYTES));
            st    <= PH_WREN;
            kick  <= 1'b1;
          end else begin
            st   <= PH_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  fus_bytegen #(.CW(CW)) u_bytegen (
    .phase    (st),
    .op       (op),
    .loading  (loading),
    .idx      (tx_idx),
    .addr     (cur_addr),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .tx_byte  (tx_byte),
    .byte_ok  (byte_ok),
    .wr_take  (wr_ready)
  );

  fus_txn #(.CW(CW)) u_txn (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (kick),
    .n_tx         (n_tx),
    .n_rx         (n_rx),
    .byte_ok      (byte_ok),
    .byte_in      (tx_byte),
    .spi_idle     (spi_idle),
    .loading      (loading),
    .tx_idx       (tx_idx),
    .rx_idx       (rx_idx),
    .rx_fire      (rx_fire),
    .done         (eng_done),
    .spi_flush    (spi_flush),
    .spi_tx_valid (spi_tx_valid),
    .spi_tx_byte  (spi_tx_byte),
    .spi_cs_n     (spi_cs_n),
    .spi_run      (spi_run),
    .spi_rx_pop   (spi_rx_pop)
  );

  AST_WREN_BEFORE_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (main_start && (op != OP_READ)) |-> wren_ok); // R3
  AST_MODIFY_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (main_start && (op != OP_READ)) |-> (cur_addr >= UPDATE_BASE)); // R2
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && spi_cs_n && !done)); // R2
  AST_BURST_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    main_start |-> (n_tx <= CW'(FIFO_DEPTH))); // R6
  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (main_start && (op == OP_PROG)) |->
      ((cur_addr >> PAGE_SHIFT) == (burst_last >> PAGE_SHIFT))); // R6
  AST_POLL_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_end && poll_wip) |=> (st == PH_POLL)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

// File: tb/flash_update_seq_bench.sv
module flash_update_seq_bench;

  localparam int          DEPTH = 16;
  localparam int          BASE  = 32'hF50000;
  localparam int          WD    = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [23:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        busy, done, err;
  logic        spi_flush, spi_tx_valid, spi_cs_n, spi_run, spi_rx_pop;
  logic [7:0]  spi_tx_byte;
  logic        spi_idle = 1'b1;
  logic [7:0]  spi_rx_byte = '0;

  always #2.5 clk = ~clk;

  flash_update_seq u_flash_update_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done), .err(err),
    .spi_flush(spi_flush), .spi_tx_valid(spi_tx_valid), .spi_tx_byte(spi_tx_byte),
    .spi_cs_n(spi_cs_n), .spi_run(spi_run), .spi_idle(spi_idle),
    .spi_rx_pop(spi_rx_pop), .spi_rx_byte(spi_rx_byte)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit timeout = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash device and shifter model ----------------
  logic [7:0] fmem [int];
  logic [7:0] txq [$];
  logic [7:0] rxq [$];
  logic [7:0] tb  [$];
  int prog_lens [$];
  int sh_cnt = 0, wip_cnt = 0, txn_count = 0;
  int erase_cnt = 0, poll_cnt = 0, wren_cnt = 0, read_cnt = 0;
  int exp_erase = 0;
  bit wel = 1'b0, prev_cs = 1'b1;

  function automatic logic [7:0] rd_mem(input int a);
    return fmem.exists(a) ? fmem[a] : 8'hFF;
  endfunction

  function automatic int hdr_addr();
    return {8'd0, tb[1], tb[2], tb[3]};
  endfunction

  function automatic logic [7:0] reply();
    int p;
    p = tb.size() - 1;
    if (tb[0] == 8'h03 && p >= 4) return rd_mem(hdr_addr() + p - 4);
    if (tb[0] == 8'h05 && p >= 1) return {7'd0, wip_cnt > 0};
    return 8'hFF;
  endfunction

  task automatic end_txn();
    int n, a;
    logic [7:0] cmd;
    n = tb.size();
    txn_count++;
    if (n == 0) begin
      check(0, "R5 empty access", 0, 1);
      return;
    end
    cmd = tb[0];
    if (wip_cnt > 0 && cmd != 8'h05) check(0, "R7 command while flash busy", cmd, 8'h05);
    case (cmd)
      8'h06: begin
        check(n == 1, "R3 write-enable length", n, 1);
        wel = 1'b1;
        wren_cnt++;
      end
      8'hD8: begin
        a = hdr_addr();
        check(wel, "R3 erase without write-enable", 0, 1);
        check(n == 4, "R4 erase length", n, 4);
        check(a >= BASE, "R2 erase address", a, BASE);
        check(a == exp_erase, "R4 erase address order", a, exp_erase);
        for (int x = a & 32'hFFFF0000; x < (a & 32'hFFFF0000) + 65536; x++)
          if (fmem.exists(x)) fmem.delete(x);
        wel = 1'b0;
        wip_cnt = 2;
        erase_cnt++;
      end
      8'h02: begin
        a = hdr_addr();
        check(wel, "R3 program without write-enable", 0, 1);
        check(n <= DEPTH && n > 4, "R6 burst size", n, DEPTH);
        check(((a + n - 5) >> 8) == (a >> 8), "R6 page crossing", a + n - 5, a);
        check(a >= BASE, "R2 program address", a, BASE);
        for (int i = 4; i < n; i++) fmem[a + i - 4] = rd_mem(a + i - 4) & tb[i];
        prog_lens.push_back(n - 4);
        wel = 1'b0;
        wip_cnt = 2;
      end
      8'h05: begin
        check(n == 2, "R7 status access length", n, 2);
        poll_cnt++;
        if (wip_cnt > 0) wip_cnt--;
      end
      8'h03: begin
        check(n <= DEPTH, "R8 read burst size", n, DEPTH);
        read_cnt++;
      end
      default: check(0, "R4 unknown command", cmd, 0);
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete();
      rxq.delete();
      sh_cnt = 0;
      prev_cs = 1'b1;
      spi_idle <= 1'b1;
      spi_rx_byte <= 8'h00;
    end else begin
      if (spi_flush) begin
        txq.delete();
        rxq.delete();
      end
      if (spi_tx_valid) txq.push_back(spi_tx_byte);
      if (spi_rx_pop && rxq.size() > 0) void'(rxq.pop_front());
      if (prev_cs && !spi_cs_n) begin
        tb.delete();
        sh_cnt = 0;
      end
      if (!spi_cs_n && spi_run && txq.size() > 0) begin
        if (sh_cnt == 2) begin
          tb.push_back(txq.pop_front());
          rxq.push_back(reply());
          sh_cnt = 0;
        end else begin
          sh_cnt++;
        end
      end
      if (!prev_cs && spi_cs_n) end_txn();
      prev_cs = spi_cs_n;
      spi_idle <= (txq.size() == 0);
      spi_rx_byte <= (rxq.size() > 0) ? rxq[0] : 8'h00;
    end
  end

  // ---------------- per-clock protocol checks (R5) ----------------
  bit pv_cs = 1'b1, pv_run = 1'b0, flushed = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > WD && !timeout) timeout = 1'b1;
    if (rst_n) begin
      if (spi_flush) begin
        check(spi_cs_n && !spi_run, "R5 flush while selected", {spi_cs_n, spi_run}, 2);
        flushed = 1'b1;
      end
      if (spi_tx_valid) begin
        check(spi_cs_n && !spi_run, "R5 load while selected", {spi_cs_n, spi_run}, 2);
        check(flushed, "R5 load before flush", 0, 1);
      end
      if (pv_cs && !spi_cs_n) begin
        check(!spi_run, "R5 select with clock on", spi_run, 0);
        flushed = 1'b0;
      end
      if (!pv_run && spi_run) check(!spi_cs_n, "R5 clock before select", spi_cs_n, 0);
      if (!pv_cs && spi_cs_n) check(spi_run, "R5 release after clock stop", spi_run, 1);
      if (pv_run && !spi_run) check(spi_cs_n, "R5 clock stop while selected", spi_cs_n, 1);
    end
    pv_cs = spi_cs_n;
    pv_run = spi_run;
  end

  // ---------------- host side ----------------
  logic [7:0] wmem [0:127];
  logic [7:0] widx = '0;
  int wtotal = 0;
  logic [7:0] rdq [$];
  int done_cnt = 0, err_cnt = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) widx <= widx + 8'd1;
      if (rd_valid) rdq.push_back(rd_data);
      if (done) done_cnt++;
      if (err) err_cnt++;
    end
  end

  always @(negedge clk) begin
    wr_valid = (int'(widx) < wtotal) && (cyc % 5 != 3);
    wr_data  = wmem[widx[6:0]];
  end

  task automatic run_req(input logic [1:0] op, input int addr, input int len, input bit accept);
    int d0, e0;
    while (!req_ready && !timeout) @(negedge clk);
    d0 = done_cnt;
    e0 = err_cnt;
    req_valid = 1'b1;
    req_op = op;
    req_addr = addr[23:0];
    req_len = len[11:0];
    @(negedge clk);
    req_valid = 1'b0;
    if (accept && !(op != 2'd0 && len == 0))
      check(busy && !req_ready, "R10 busy while working", {busy, req_ready}, 2);
    while (done_cnt == d0 && err_cnt == e0 && !timeout) @(negedge clk);
    @(negedge clk);
  endtask

  int t0, d0, e0, p0, w0;
  logic [7:0] expv;

  initial begin
    fmem[0] = 8'hA5;
    fmem[1] = 8'h5A;
    fmem[2] = 8'h3C;
    fmem[BASE + 16] = 8'h00;
    for (int i = 0; i < 128; i++) wmem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n && !spi_run && !busy && req_ready,
          "R1 reset state", {spi_cs_n, spi_run, busy, req_ready}, 4'b1001);

    // R2: rejected requests
    t0 = txn_count; d0 = done_cnt; e0 = err_cnt;
    run_req(2'd1, 32'h100000, 8, 1'b0);
    run_req(2'd0, BASE - 1, 0, 1'b0);
    run_req(2'd3, BASE, 4, 1'b0);
    check(err_cnt == e0 + 3, "R2 error pulses", err_cnt - e0, 3);
    check(done_cnt == d0, "R2 no completion on reject", done_cnt - d0, 0);
    check(txn_count == t0 && spi_cs_n, "R2 flash untouched", txn_count - t0, 0);

    // R10: zero-length program
    t0 = txn_count; d0 = done_cnt;
    run_req(2'd1, BASE, 0, 1'b1);
    check(done_cnt == d0 + 1, "R10 zero-length completes", done_cnt - d0, 1);
    check(txn_count == t0, "R10 zero-length no access", txn_count - t0, 0);

    // R9 / R3 / R7: sector erase
    exp_erase = BASE; p0 = poll_cnt; w0 = wren_cnt; d0 = done_cnt;
    run_req(2'd0, BASE, 0, 1'b1);
    check(erase_cnt == 1, "R9 single erase access", erase_cnt, 1);
    check(wren_cnt == w0 + 1, "R3 write-enable per erase", wren_cnt - w0, 1);
    check(poll_cnt == p0 + 3, "R7 status polls after erase", poll_cnt - p0, 3);
    check(done_cnt == d0 + 1, "R10 erase done once", done_cnt - d0, 1);

    // R6: split program across page and FIFO limits
    p0 = poll_cnt; w0 = wren_cnt; d0 = done_cnt;
    prog_lens.delete();
    wtotal = 30;
    run_req(2'd1, BASE + 32'hFA, 30, 1'b1);
    check(prog_lens.size() == 3, "R6 burst count", prog_lens.size(), 3);
    if (prog_lens.size() == 3) begin
      check(prog_lens[0] == 6, "R6 first burst stops at page end", prog_lens[0], 6);
      check(prog_lens[1] == 12 && prog_lens[2] == 12, "R6 FIFO-bounded bursts",
            {prog_lens[1][15:0], prog_lens[2][15:0]}, 32'h000C000C);
    end
    check(wren_cnt == w0 + 3, "R3 write-enable per program", wren_cnt - w0, 3);
    check(poll_cnt == p0 + 9, "R7 status polls after programs", poll_cnt - p0, 9);
    check(int'(widx) == 30, "R6 stream bytes consumed", widx, 30);
    check(done_cnt == d0 + 1, "R10 program done once", done_cnt - d0, 1);
    for (int i = 0; i < 30; i++)
      check(rd_mem(BASE + 32'hFA + i) == wmem[i], "R6 flash contents",
            rd_mem(BASE + 32'hFA + i), wmem[i]);

    // R8: read back across the written region
    rdq.delete();
    run_req(2'd2, BASE + 32'hF0, 20, 1'b1);
    check(rdq.size() == 20, "R8 read byte count", rdq.size(), 20);
    for (int i = 0; i < 20 && i < rdq.size(); i++) begin
      expv = (i < 10) ? 8'hFF : wmem[i - 10];
      check(rdq[i] == expv, "R8 read data", rdq[i], expv);
    end

    // R9: erased byte reads 0xFF
    rdq.delete();
    run_req(2'd2, BASE + 16, 2, 1'b1);
    check(rdq.size() == 2 && rdq[0] == 8'hFF && rdq[1] == 8'hFF, "R9 erased read",
          (rdq.size() == 2) ? {rdq[0], rdq[1]} : 16'h0, 16'hFFFF);

    // R8: read of protected region allowed
    rdq.delete();
    run_req(2'd2, 0, 3, 1'b1);
    check(rdq.size() == 3 && rdq[0] == 8'hA5 && rdq[1] == 8'h5A && rdq[2] == 8'h3C,
          "R8 golden read", (rdq.size() == 3) ? {rdq[0], rdq[1], rdq[2]} : 24'h0, 24'hA55A3C);

    if (timeout) check(0, "watchdog expired", cyc, WD);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule